// File: doc/BRIEF.md
# Dual-Channel Sensor SPI Readout Sequencer

This block is an SPI master that owns a two-channel current/voltage sampling sensor. After the chip's reset it pulses the sensor's active-high reset line and waits for the sensor to settle. It then writes the sensor's two configuration registers and reads the sensor's status register until the sensor reports ready or a retry budget runs out. Once the sensor is ready, each one-cycle request starts a single six-byte burst with chip select held low. The burst returns the current code and the voltage code together, so the two codes always come from the same sample pair.

The link runs in SPI mode 0 with 8-bit words, most significant bit first. SCLK is an integer division of the system clock. All waits are cycle counts that the block works out from the clock frequency and from times given in nanoseconds. A request that arrives before bring-up has finished is turned away with a one-cycle error pulse. A failed bring-up leaves the error flag set until the next reset.

Top module: `sensor_spi_seq`

## Requirements
- R1: While `rst_n` is low, `sensor_rst`, `cs_n` and `busy` are 1, `sclk`, `err` and `meas_done` are 0, and both codes are 0. After release, `sensor_rst` stays high for exactly RST_PULSE cycles (RST_PULSE_NS converted to clock cycles), counted in clock edges from release.
- R2: After `sensor_rst` falls, `cs_n` stays high for at least RST_WAIT cycles before the first frame.
- R3: The link uses SPI mode 0. `sclk` is low whenever `cs_n` is high, MOSI changes only after a falling SCLK edge, and MISO is sampled on the rising edge. Bytes go out most significant bit first.
- R4: Bring-up begins with two separate 3-byte write frames, in this order: 0x00 0x00 0x99, then 0x00 0x01 0x00. A command word is 16 bits, sent high byte first. Bit 15 is 1 for a read, and bits 14..0 hold the register address.
- R5: A status poll is the 3-byte frame 0x81 0x03 0x00. The byte received in the third slot is the status. After a poll that does not return 0x01, `cs_n` stays high for at least POLL_GAP cycles before the next poll.
- R6: If POLL_MAX polls in a row fail to return 0x01, `err` goes high and stays high, `busy` goes low, and no further frame is ever issued, even when `meas_req` is pulsed.
- R7: The first poll that returns 0x01 ends bring-up. `busy` falls, `err` stays 0, and no further poll is sent.
- R8: A measurement is one 6-byte frame, 0x82 0x03 0x00 0x00 0x00 0x00. Received bytes 2 and 3 form the current code and bytes 4 and 5 form the voltage code, high byte first in each case.
- R9: Each code is 12 bits wide. Bits 15..12 of `cur_code` and `volt_code` are always 0, whatever the sensor returns.
- R10: `busy` is 1 from the cycle after an accepted request until the result appears. `meas_done` is a one-cycle pulse, and in that cycle the codes hold the new values and `busy` is 0.
- R11: A `meas_req` that arrives before bring-up has finished raises `err` for exactly the next cycle. It adds no frame and does not change the bring-up sequence.
- R12: A `meas_req` that arrives while a measurement is running is ignored. No second frame starts, no second result is produced, and `err` stays 0.
- R13: `cs_n` stays high for at least one SCLK period between any two frames.
- R14: A `meas_req` in the same cycle as `meas_done` is accepted and starts a new measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| meas_req | input | 1 | One-cycle request for a paired measurement |
| cur_code | output | 16 | Latest current code, 12 bits zero-extended |
| volt_code | output | 16 | Latest voltage code, 12 bits zero-extended |
| meas_done | output | 1 | One-cycle pulse when new codes are present |
| busy | output | 1 | Bring-up or measurement in progress |
| err | output | 1 | Bring-up failed (held), or one-cycle pulse for a rejected request |
| sensor_rst | output | 1 | Active-high reset to the sensor |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | SPI data to the sensor |
| cs_n | output | 1 | SPI chip select, active low |
| miso | input | 1 | SPI data from the sensor |

## Verification
Two functions can fall in the same cycle: the completion of one measurement and the acceptance of the next. The bench waits on the falling clock edge for `meas_done` and, in that same cycle, raises `meas_req` and changes the value its sensor model will return. The coincidence is judged correct only if `busy` is high one cycle later, a second 6-byte frame with the exact command bytes follows after the chip-select gap, and the second result carries the new values rather than a copy of the first. A second pairing, a request arriving while a measurement is already running, is judged by the absence of any extra frame or result.

// File: rtl/sspi_pkg.sv
package sspi_pkg;

  typedef enum logic [3:0] {
    ST_RSTP,
    ST_RWAIT,
    ST_CFGA,
    ST_CFGB,
    ST_POLL,
    ST_PGAP,
    ST_READY,
    ST_MEAS,
    ST_FAIL
  } seq_state_t;

  localparam int FRAME_BYTES = 6;
  localparam int FRAME_W     = FRAME_BYTES * 8;

  localparam logic [14:0] REG_CFG_A  = 15'h0000;
  localparam logic [14:0] REG_CFG_B  = 15'h0001;
  localparam logic [14:0] REG_STAT   = 15'h0103;
  localparam logic [14:0] REG_BURST  = 15'h0203;
  localparam logic [7:0]  CFG_A_VAL  = 8'h99;
  localparam logic [7:0]  CFG_B_VAL  = 8'h00;
  localparam logic [7:0]  STAT_READY = 8'h01;

  // Convert a time in ns into whole clock cycles, never less than one.
  function automatic int ns_to_cycles(input longint hz, input longint ns);
    longint c;
    c = (ns * (hz / 1000000)) / 1000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  // SCLK half period in system clocks.
  function automatic int half_div(input longint hz, input longint sclk_hz);
    longint h;
    h = hz / (2 * sclk_hz);
    return (h < 1) ? 1 : int'(h);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic logic [15:0] cmd_word(input logic rd, input logic [14:0] addr);
    return {rd, addr};
  endfunction

  // Three-byte frame, left aligned in the shift register.
  function automatic logic [FRAME_W-1:0] frame3(input logic [15:0] cmd, input logic [7:0] d);
    return {cmd, d, {(FRAME_W-24){1'b0}}};
  endfunction

  function automatic logic [15:0] code12(input logic [15:0] raw);
    return raw & 16'h0FFF;
  endfunction

endpackage

// File: rtl/seq_delay.sv
module seq_delay #(
  parameter int W         = 8,
  parameter int RESET_VAL = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= W'(RESET_VAL);
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - W'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int HALF_DIV = 2,
  parameter int GAP_CYC  = 4,
  parameter int MAXB     = 6,
  parameter int RXW      = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [$clog2(MAXB+1)-1:0]  nbytes,
  input  logic [MAXB*8-1:0]          tx,
  output logic                       busy,
  output logic                       done,
  output logic [RXW-1:0]             rx,
  output logic                       sclk,
  output logic                       mosi,
  output logic                       cs_n,
  input  logic                       miso
);
  localparam int TXW = MAXB * 8;
  localparam int BCW = $clog2(TXW + 1);
  localparam int DW  = $clog2((HALF_DIV > 1) ? HALF_DIV : 2);
  localparam int GW  = $clog2(GAP_CYC + 1);

  typedef enum logic [1:0] {E_IDLE, E_SHIFT, E_GAP} eng_t;

  eng_t           est;
  logic [DW-1:0]  div_cnt;
  logic [GW-1:0]  gap_cnt;
  logic [BCW-1:0] bits_left;
  logic [TXW-1:0] tx_sh;
  logic [RXW-1:0] rx_sh;
  logic           sclk_q, cs_q, done_q;

  // Named events for the assertions below.
  wire half_tick = (div_cnt == DW'(HALF_DIV - 1));
  wire edge_rise = (est == E_SHIFT) && half_tick && !sclk_q;
  wire edge_fall = (est == E_SHIFT) && half_tick && sclk_q;
  wire last_bit  = (bits_left == BCW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est       <= E_IDLE;
      div_cnt   <= '0;
      gap_cnt   <= '0;
      bits_left <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      sclk_q    <= 1'b0;
      cs_q      <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (est)
        E_IDLE: begin
          if (start) begin
            tx_sh     <= tx;
            rx_sh     <= '0;
            bits_left <= BCW'({nbytes, 3'b000});
            cs_q      <= 1'b0;
            div_cnt   <= '0;
            est       <= E_SHIFT;
          end
        end
        E_SHIFT: begin
          div_cnt <= half_tick ? '0 : div_cnt + DW'(1);
          if (edge_rise) begin
            sclk_q <= 1'b1;
            rx_sh  <= {rx_sh[RXW-2:0], miso};
          end
          if (edge_fall) begin
            sclk_q <= 1'b0;
            if (last_bit) begin
              cs_q    <= 1'b1;
              gap_cnt <= '0;
              est     <= E_GAP;
            end else begin
              bits_left <= bits_left - BCW'(1);
              tx_sh     <= tx_sh << 1;
            end
          end
        end
        E_GAP: begin
          if (gap_cnt == GW'(GAP_CYC - 1)) begin
            done_q <= 1'b1;
            est    <= E_IDLE;
          end else begin
            gap_cnt <= gap_cnt + GW'(1);
          end
        end
        default: est <= E_IDLE;
      endcase
    end
  end

  assign busy = (est != E_IDLE);
  assign done = done_q;
  assign rx   = rx_sh;
  assign sclk = sclk_q;
  assign mosi = tx_sh[TXW-1];
  assign cs_n = cs_q;

  // Cycles chip select has been high, saturating at the required gap.
  logic [GW-1:0] cs_hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cs_hi_cnt <= GW'(GAP_CYC);
    else if (!cs_q)                       cs_hi_cnt <= '0;
    else if (cs_hi_cnt != GW'(GAP_CYC))   cs_hi_cnt <= cs_hi_cnt + GW'(1);
  end

  a_r3_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> !sclk_q);

  a_r3_mosi_held_in_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(tx_sh[TXW-1]));

  a_r13_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> (cs_hi_cnt == GW'(GAP_CYC)));
endmodule

// File: rtl/sensor_spi_seq.sv
module sensor_spi_seq
  import sspi_pkg::*;
#(
  parameter longint CLK_HZ       = 100_000_000,
  parameter longint SCLK_HZ      = 1_000_000,
  parameter longint RST_PULSE_NS = 5_000,
  parameter longint RST_WAIT_NS  = 600_000,
  parameter longint POLL_GAP_NS  = 1_500_000,
  parameter int     POLL_MAX     = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        meas_req,
  output logic [15:0] cur_code,
  output logic [15:0] volt_code,
  output logic        meas_done,
  output logic        busy,
  output logic        err,
  output logic        sensor_rst,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n,
  input  logic        miso
);
  localparam int HALF  = half_div(CLK_HZ, SCLK_HZ);
  localparam int GAP   = 2 * HALF;
  localparam int P_CYC = ns_to_cycles(CLK_HZ, RST_PULSE_NS);
  localparam int W_CYC = ns_to_cycles(CLK_HZ, RST_WAIT_NS);
  localparam int G_CYC = ns_to_cycles(CLK_HZ, POLL_GAP_NS);
  localparam int TMAX  = max3(P_CYC, W_CYC, G_CYC);
  localparam int TW    = $clog2(TMAX + 1);
  localparam int PCW   = $clog2(POLL_MAX + 1);
  localparam int NBW   = $clog2(FRAME_BYTES + 1);
  localparam int RXW   = 32;

  seq_state_t       state;
  logic             launched;
  logic [PCW-1:0]   poll_cnt;
  logic             rej_q, done_q;
  logic [15:0]      cur_q, volt_q;

  logic             eng_start, eng_busy, eng_done;
  logic [NBW-1:0]   eng_nbytes;
  logic [FRAME_W-1:0] eng_tx;
  logic [RXW-1:0]   eng_rx;
  logic             tmr_load, tmr_exp;
  logic [TW-1:0]    tmr_val;

  // Named internal events.
  wire frame_state = (state == ST_CFGA) || (state == ST_CFGB) ||
                     (state == ST_POLL) || (state == ST_MEAS);
  wire stat_ok     = (eng_rx[7:0] == STAT_READY);
  wire poll_last   = (poll_cnt == PCW'(POLL_MAX - 1));
  wire poll_retry  = (state == ST_POLL) && eng_done && !stat_ok && !poll_last;
  wire req_reject  = meas_req && (state != ST_READY) && (state != ST_MEAS);

  always_comb begin
    eng_nbytes = NBW'(3);
    eng_tx     = '0;
    case (state)
      ST_CFGA: eng_tx = frame3(cmd_word(1'b0, REG_CFG_A), CFG_A_VAL);
      ST_CFGB: eng_tx = frame3(cmd_word(1'b0, REG_CFG_B), CFG_B_VAL);
      ST_POLL: eng_tx = frame3(cmd_word(1'b1, REG_STAT), 8'h00);
      ST_MEAS: begin
        eng_nbytes = NBW'(FRAME_BYTES);
        eng_tx     = {cmd_word(1'b1, REG_BURST), {(FRAME_W-16){1'b0}}};
      end
      default: ;
    endcase
  end

  assign eng_start = frame_state && !launched && !eng_busy;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (state == ST_RSTP && tmr_exp) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(W_CYC - 1);
    end else if (poll_retry) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(G_CYC - 1);
    end
  end

  seq_delay #(.W(TW), .RESET_VAL(P_CYC - 1)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  spi_frame_engine #(.HALF_DIV(HALF), .GAP_CYC(GAP), .MAXB(FRAME_BYTES), .RXW(RXW)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (eng_start),
    .nbytes (eng_nbytes),
    .tx     (eng_tx),
    .busy   (eng_busy),
    .done   (eng_done),
    .rx     (eng_rx),
    .sclk   (sclk),
    .mosi   (mosi),
    .cs_n   (cs_n),
    .miso   (miso)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RSTP;
      launched <= 1'b0;
      poll_cnt <= '0;
      rej_q    <= 1'b0;
      done_q   <= 1'b0;
      cur_q    <= '0;
      volt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      rej_q  <= req_reject;
      if (eng_start) launched <= 1'b1;
      case (state)
        ST_RSTP:  if (tmr_exp) state <= ST_RWAIT;
        ST_RWAIT: if (tmr_exp) state <= ST_CFGA;
        ST_CFGA: if (eng_done) begin
          launched <= 1'b0;
          state    <= ST_CFGB;
        end
        ST_CFGB: if (eng_done) begin
          launched <= 1'b0;
          state    <= ST_POLL;
        end
        ST_POLL: if (eng_done) begin
          launched <= 1'b0;
          if (stat_ok)        state <= ST_READY;
          else if (poll_last) state <= ST_FAIL;
          else begin
            poll_cnt <= poll_cnt + PCW'(1);
            state    <= ST_PGAP;
          end
        end
        ST_PGAP:  if (tmr_exp) state <= ST_POLL;
        ST_READY: if (meas_req) state <= ST_MEAS;
        ST_MEAS: if (eng_done) begin
          launched <= 1'b0;
          cur_q    <= code12(eng_rx[31:16]);
          volt_q   <= code12(eng_rx[15:0]);
          done_q   <= 1'b1;
          state    <= ST_READY;
        end
        ST_FAIL:  state <= ST_FAIL;
        default:  state <= ST_FAIL;
      endcase
    end
  end

  assign cur_code   = cur_q;
  assign volt_code  = volt_q;
  assign meas_done  = done_q;
  assign busy       = (state != ST_READY) && (state != ST_FAIL);
  assign err        = (state == ST_FAIL) || rej_q;
  assign sensor_rst = (state == ST_RSTP);

  a_r1_no_traffic_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    sensor_rst |-> cs_n);

  a_r6_fail_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAIL) |-> (cs_n && !eng_busy));

  a_r10_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |-> !busy);

  a_r10_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |=> !meas_done);

  a_r9_codes_12bit: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |-> (cur_code[15:12] == 4'h0 && volt_code[15:12] == 4'h0));
endmodule

// File: tb/sensor_spi_seq_bench.sv
module sensor_spi_seq_bench;
  localparam longint HZ  = 250_000_000;
  localparam longint SHZ = 62_500_000;
  localparam int PMAX  = 4;
  localparam int P_CYC = 10;   // 40 ns at 4 ns per cycle
  localparam int W_CYC = 50;   // 200 ns
  localparam int G_CYC = 100;  // 400 ns
  localparam int SPER  = 4;    // SCLK period in clocks
  localparam int LIMIT = 150000;

  logic clk = 1'b0, rst_n = 1'b0, meas_req = 1'b0, miso = 1'b0;
  logic [15:0] cur_code, volt_code;
  logic meas_done, busy, err, sensor_rst, sclk, mosi, cs_n;

  always #2 clk = ~clk;

  sensor_spi_seq #(
    .CLK_HZ(HZ), .SCLK_HZ(SHZ), .RST_PULSE_NS(40), .RST_WAIT_NS(200),
    .POLL_GAP_NS(400), .POLL_MAX(PMAX)
  ) u_sensor_spi_seq (
    .clk(clk), .rst_n(rst_n), .meas_req(meas_req), .cur_code(cur_code),
    .volt_code(volt_code), .meas_done(meas_done), .busy(busy), .err(err),
    .sensor_rst(sensor_rst), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard queues filled by the driver.
  int          exp_len[$];
  logic [47:0] exp_dat[$];
  logic [15:0] exp_cur[$], exp_volt[$];

  task automatic push_frame(input int n, input logic [47:0] d);
    exp_len.push_back(n);
    exp_dat.push_back(d);
  endtask

  task automatic expect_bringup(input int polls);
    push_frame(3, {24'h000099, 24'h0});   // R4 first write
    push_frame(3, {24'h000100, 24'h0});   // R4 second write
    for (int i = 0; i < polls; i++) push_frame(3, {24'h810300, 24'h0});  // R5
  endtask

  task automatic expect_meas(input logic [15:0] c, input logic [15:0] v);
    push_frame(6, {16'h8203, 32'h0});     // R8
    exp_cur.push_back(c & 16'h0FFF);      // R9
    exp_volt.push_back(v & 16'h0FFF);
  endtask

  // Sensor model (SPI mode 0 slave).
  int          bitcnt = 0, poll_cnt = 0, ready_after = 0, rise_cyc = 0;
  bit          framing = 0, last_failed_poll = 0, seen_frame = 0;
  logic [47:0] shin = '0;
  logic [15:0] cmd = '0;
  logic [15:0] s_cur = '0, s_volt = '0;

  function automatic logic [7:0] resp_byte(input int idx);
    if (idx < 2) return 8'h00;
    if (cmd == 16'h8103) return (idx == 2 && poll_cnt >= ready_after) ? 8'h01 : 8'h00;
    if (cmd == 16'h8203) begin
      case (idx)
        2: return s_cur[15:8];
        3: return s_cur[7:0];
        4: return s_volt[15:8];
        5: return s_volt[7:0];
        default: return 8'h00;
      endcase
    end
    return 8'h00;
  endfunction

  always @(negedge cs_n) begin
    chk(sclk == 1'b0, "R3 sclk low at frame start", sclk, 0);
    if (seen_frame) chk(cyc - rise_cyc >= SPER, "R13 cs high gap", cyc - rise_cyc, SPER);
    if (last_failed_poll) chk(cyc - rise_cyc >= G_CYC, "R5 poll spacing", cyc - rise_cyc, G_CYC);
    framing = 1; bitcnt = 0; shin = '0; cmd = '0; miso = 1'b0;
  end

  always @(posedge sclk) if (!cs_n) begin
    shin = {shin[46:0], mosi};
    bitcnt++;
    if (bitcnt == 16) cmd = shin[15:0];
  end

  always @(negedge sclk) if (!cs_n) begin
    logic [7:0] b;
    b = resp_byte(bitcnt / 8);
    miso = b[7 - (bitcnt % 8)];
  end

  always @(posedge cs_n) if (framing) begin
    int          nb;
    logic [47:0] d;
    framing = 0;
    seen_frame = 1;
    nb = bitcnt / 8;
    d  = shin << (48 - bitcnt);
    chk(bitcnt % 8 == 0, "R3 whole bytes", bitcnt, nb * 8);
    if (exp_len.size() == 0) begin
      chk(0, "R6 R12 unexpected frame", d, 0);
    end else begin
      int          el;
      logic [47:0] ed;
      el = exp_len.pop_front();
      ed = exp_dat.pop_front();
      chk(nb == el, "R4 R5 R8 frame length", nb, el);
      chk(d == ed, "R4 R5 R8 frame bytes", d, ed);
    end
    if (cmd == 16'h8103) begin
      last_failed_poll = (poll_cnt < ready_after);
      poll_cnt++;
    end else last_failed_poll = 0;
    rise_cyc = cyc;
  end

  // Result monitor.
  bit prev_done = 0;
  always @(negedge clk) begin
    if (meas_done) begin
      if (exp_cur.size() == 0) chk(0, "R12 unexpected result", cur_code, 0);
      else begin
        logic [15:0] ec, ev;
        ec = exp_cur.pop_front();
        ev = exp_volt.pop_front();
        chk(cur_code == ec, "R8 R9 current code", cur_code, ec);
        chk(volt_code == ev, "R8 R9 voltage code", volt_code, ev);
      end
      chk(!busy, "R10 busy low at done", busy, 0);
      chk(!prev_done, "R10 done single pulse", prev_done, 0);
    end
    prev_done = meas_done;
  end

  task automatic do_reset(input int ready_at);
    @(negedge clk);
    rst_n = 1'b0;
    ready_after = ready_at;
    poll_cnt = 0;
    last_failed_poll = 0;
    seen_frame = 0;
    repeat (3) @(negedge clk);
    chk(sensor_rst && cs_n && busy, "R1 reset outputs high", {sensor_rst, cs_n, busy}, 3'b111);
    chk(!sclk && !err && !meas_done, "R1 reset outputs low", {sclk, err, meas_done}, 0);
    chk(cur_code == 0 && volt_code == 0, "R1 reset codes", {cur_code, volt_code}, 0);
    rst_n = 1'b1;
  endtask

  task automatic check_startup();
    int n, m;
    n = 0;
    do begin @(negedge clk); n++; end while (sensor_rst);
    chk(n == P_CYC, "R1 reset pulse length", n, P_CYC);
    m = 0;
    do begin @(negedge clk); m++; end while (cs_n);
    chk(m >= W_CYC, "R2 settle wait", m, W_CYC);
  endtask

  task automatic pulse_req();
    meas_req = 1'b1;
    @(negedge clk);
    meas_req = 1'b0;
  endtask

  task automatic wait_done();
    while (!meas_done) @(negedge clk);
  endtask

  initial begin
    int lows;
    // Scenario A: sensor never reports ready.
    expect_bringup(PMAX);
    do_reset(1000);
    check_startup();
    repeat (5) @(negedge clk);
    chk(err == 0, "R11 err low before request", err, 0);
    pulse_req();
    chk(err == 1, "R11 reject pulse", err, 1);
    @(negedge clk);
    chk(err == 0, "R11 reject pulse one cycle", err, 0);
    while (busy) @(negedge clk);
    chk(err == 1, "R6 error held after failed polls", err, 1);
    chk(exp_len.size() == 0, "R6 poll count", exp_len.size(), 0);
    @(negedge clk);
    pulse_req();
    lows = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!cs_n) lows++;
    end
    chk(lows == 0, "R6 no traffic after failure", lows, 0);
    chk(err == 1 && !busy, "R6 error stays", {err, busy}, 2'b10);

    // Scenario B: ready on the third poll.
    expect_bringup(3);
    do_reset(2);
    check_startup();
    while (busy) @(negedge clk);
    chk(err == 0, "R7 no error after ready", err, 0);
    repeat (250) @(negedge clk);
    chk(exp_len.size() == 0, "R7 polling stopped", exp_len.size(), 0);

    // Plain measurement.
    s_cur = 16'hF123; s_volt = 16'h0ABC;
    expect_meas(s_cur, s_volt);
    pulse_req();
    chk(busy == 1, "R10 busy after request", busy, 1);
    wait_done();
    @(negedge clk);

    // Request during a running measurement is ignored.
    s_cur = 16'h1FFF; s_volt = 16'hE001;
    expect_meas(s_cur, s_volt);
    pulse_req();
    repeat (20) @(negedge clk);
    pulse_req();
    chk(err == 0, "R12 no error for ignored request", err, 0);
    wait_done();
    repeat (300) @(negedge clk);
    chk(exp_len.size() == 0 && cs_n, "R12 single frame", exp_len.size(), 0);

    // Request in the cycle the previous result appears.
    s_cur = 16'h0800; s_volt = 16'h0FFF;
    expect_meas(s_cur, s_volt);
    pulse_req();
    wait_done();
    s_cur = 16'h5001; s_volt = 16'hA800;
    expect_meas(s_cur, s_volt);
    pulse_req();
    chk(busy == 1, "R14 accepted with done", busy, 1);
    @(negedge clk);
    wait_done();
    repeat (100) @(negedge clk);
    chk(exp_len.size() == 0 && exp_cur.size() == 0, "R14 second result delivered",
        exp_len.size() + exp_cur.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc >= LIMIT);
    chk(0, "watchdog expired", cyc, LIMIT);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule